// File: doc/BRIEF.md
# Ringing Line Switch State Controller

This block holds the control logic for a telephone line access switch that can route a ringing generator onto the line, or connect the line to the talk path. It drives three switch enables: a ringing return switch, a ringing switch and a set of break switches. From a ringing request, a latch enable, a shutdown line and a zero-current-crossing pulse, it decides each switch state on every clock.

The ringing switch is the only switch that never opens on command alone. When the ringing switch is commanded off, it stays closed until the next zero-crossing pulse arrives. The other switches follow their command in the same cycle. Two transition paths follow from this. When the request is dropped while the shutdown line is released, the break switches close while the ringing switch is still closed (make-before-break). When the shutdown line is pulled low, every other switch opens, and the ringing switch opens later, at the zero crossing (break-before-make).

All four inputs pass through a synchronizer chain of `SYNC_STAGES` flops. The switch enables and a release-pending flag are registered outputs.

Top module: `ring_switch_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four outputs read 0.
- R2: With the shutdown line reading 1 and the held request at 1, the ringing return switch and the ringing switch are on, and the break switches are off.
- R3: With the shutdown line reading 1, the held request at 0 and no release pending, the ringing return switch and the ringing switch are off, and the break switches are on.
- R4: If the held request falls to 0 while the shutdown line reads 1, the ringing return switch opens and the break switches close in the same cycle. The ringing switch stays on until a zero-crossing pulse.
- R5: While the shutdown line reads 0, the ringing return switch and the break switches are off, and the ringing switch never goes from off to on.
- R6: If the shutdown line goes to 0 while the ringing switch is on, the ringing switch stays on until the next zero-crossing pulse, and then opens.
- R7: Once the shutdown line reads 1 again, the switches follow the held request as in R2 and R3.
- R8: While the latch enable is 0, the held request follows the ringing request input.
- R9: While the latch enable is 1, the held request keeps its value and changes on the ringing request input have no effect on the switches.
- R10: A zero-crossing pulse has no effect when no ringing switch release is pending. This covers the talk state, and the ringing state while ringing is commanded.
- R11: `release_pend` is 1 exactly while the ringing switch is on but not commanded on. A zero-crossing pulse clears it, together with the ringing switch, in the same cycle.
- R12: A change on any input reaches the outputs SYNC_STAGES+1 clock cycles later. A shutdown input level of 1 means released (normal operation), and 0 means forced all-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_req | input | 1 | Ringing request, 1 = ringing, 0 = talk |
| hold_en | input | 1 | Latch enable, 0 = transparent, 1 = hold |
| shdn_n | input | 1 | Shutdown line as read, 1 = released, 0 = forced off |
| zc_pulse | input | 1 | Zero-current-crossing pulse from the external comparator |
| ret_sw_on | output | 1 | Ringing return switch enable |
| ring_sw_on | output | 1 | Ringing switch enable |
| brk_sw_on | output | 1 | Break switch enable |
| release_pend | output | 1 | Ringing switch waiting for a zero crossing |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default 2. This exercises a deeper input pipeline, so the model's delay line has to match a latency of four cycles. With that setting, the make-before-break and break-before-make paths can be held open for many cycles before a zero-crossing pulse arrives. The bench also drives stray zero-crossing pulses in the talk state and in a commanded ringing state, and toggles the request both while it is held and while the shutdown line is low.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef struct packed {
    logic ret;
    logic ring;
    logic brk;
  } sw_set_t;

  localparam int IN_W = 4;
  localparam int IDX_REQ  = 0;
  localparam int IDX_HOLD = 1;
  localparam int IDX_SHDN = 2;
  localparam int IDX_ZC   = 3;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s+1] <= '0;
      else     chain[s+1] <= chain[s];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/rsc_req_latch.sv
module rsc_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic hold,
  output logic req_eff
);
  logic held_q;

  assign req_eff = hold ? held_q : req;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= req_eff;
  end

  p_hold_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(held_q));
  p_transparent_r8: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (held_q == $past(req)));
endmodule

// File: rtl/rsc_switch_fsm.sv
module rsc_switch_fsm
  import rsc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_eff,
  input  logic    shdn_ok,
  input  logic    zc,
  output sw_set_t sw,
  output logic    pend
);
  sw_set_t sw_q;
  sw_set_t sw_d;
  logic    pend_q;
  logic    pend_d;
  logic    ring_cmd;
  logic    ring_keep;

  assign ring_cmd  = shdn_ok && req_eff;
  assign ring_keep = sw_q.ring && !zc;

  always_comb begin
    sw_d.ret  = ring_cmd;
    sw_d.brk  = shdn_ok && !req_eff;
    sw_d.ring = ring_cmd || ring_keep;
    pend_d    = !ring_cmd && ring_keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      sw_q   <= sw_d;
      pend_q <= pend_d;
    end
  end

  assign sw   = sw_q;
  assign pend = pend_q;

  p_ringing_r2: assert property (@(posedge clk) disable iff (rst)
    (shdn_ok && req_eff) |=> (sw_q.ret && sw_q.ring && !sw_q.brk && !pend_q));
  p_mbb_r4: assert property (@(posedge clk) disable iff (rst)
    (shdn_ok && !req_eff) |=> (sw_q.brk && !sw_q.ret));
  p_no_close_r5: assert property (@(posedge clk) disable iff (rst)
    (!shdn_ok && !sw_q.ring) |=> (!sw_q.ring && !sw_q.brk && !sw_q.ret));
  p_ring_waits_r6: assert property (@(posedge clk) disable iff (rst)
    (sw_q.ring && !zc) |=> sw_q.ring);
  p_zc_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (zc && !(shdn_ok && req_eff)) |=> (!sw_q.ring && !pend_q));
  p_pend_ring_r11: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> sw_q.ring);
endmodule

// File: rtl/ring_switch_ctrl.sv
module ring_switch_ctrl
  import rsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_req,
  input  logic hold_en,
  input  logic shdn_n,
  input  logic zc_pulse,
  output logic ret_sw_on,
  output logic ring_sw_on,
  output logic brk_sw_on,
  output logic release_pend
);
  logic [IN_W-1:0] raw_in;
  logic [IN_W-1:0] syn_in;
  logic            req_eff;
  sw_set_t         sw;
  logic            pend;

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_REQ]  = ring_req;
    raw_in[IDX_HOLD] = hold_en;
    raw_in[IDX_SHDN] = shdn_n;
    raw_in[IDX_ZC]   = zc_pulse;
  end

  rsc_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  rsc_req_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .req     (syn_in[IDX_REQ]),
    .hold    (syn_in[IDX_HOLD]),
    .req_eff (req_eff)
  );

  rsc_switch_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_eff (req_eff),
    .shdn_ok (syn_in[IDX_SHDN]),
    .zc      (syn_in[IDX_ZC]),
    .sw      (sw),
    .pend    (pend)
  );

  assign ret_sw_on    = sw.ret;
  assign ring_sw_on   = sw.ring;
  assign brk_sw_on    = sw.brk;
  assign release_pend = pend;

  p_off_in_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!ret_sw_on && !ring_sw_on && !brk_sw_on && !release_pend));
endmodule

// File: tb/tb_ring_switch_ctrl.sv
module tb_ring_switch_ctrl;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_req = 1'b0, hold_en = 1'b0, shdn_n = 1'b0, zc_pulse = 1'b0;
  logic ret_sw_on, ring_sw_on, brk_sw_on, release_pend;

  int total = 0;
  int bad = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  ring_switch_ctrl #(.SYNC_STAGES(S)) dut (
    .clk(clk), .rst(rst), .ring_req(ring_req), .hold_en(hold_en),
    .shdn_n(shdn_n), .zc_pulse(zc_pulse), .ret_sw_on(ret_sw_on),
    .ring_sw_on(ring_sw_on), .brk_sw_on(brk_sw_on), .release_pend(release_pend)
  );

  // behavioural reference: input delay line plus switch model
  bit d_req[S], d_hold[S], d_shdn[S], d_zc[S];
  bit m_held, m_ret, m_ring, m_brk, m_pend;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < S; i++) begin
        d_req[i] = 0; d_hold[i] = 0; d_shdn[i] = 0; d_zc[i] = 0;
      end
      m_held = 0; m_ret = 0; m_ring = 0; m_brk = 0; m_pend = 0;
    end else begin
      bit r, ok, z, want_ring;
      r = d_hold[S-1] ? m_held : d_req[S-1];
      ok = d_shdn[S-1];
      z = d_zc[S-1];
      m_held = r;
      want_ring = ok && r;
      if (want_ring) begin
        m_ret = 1; m_brk = 0; m_ring = 1; m_pend = 0;
      end else begin
        m_ret = 0;
        m_brk = ok;
        if (z) m_ring = 0;
        m_pend = m_ring;
      end
      for (int i = S-1; i > 0; i--) begin
        d_req[i] = d_req[i-1]; d_hold[i] = d_hold[i-1];
        d_shdn[i] = d_shdn[i-1]; d_zc[i] = d_zc[i-1];
      end
      d_req[0] = ring_req; d_hold[0] = hold_en; d_shdn[0] = shdn_n; d_zc[0] = zc_pulse;
    end
  end

  task automatic check_outs();
    total++;
    if ({ret_sw_on, ring_sw_on, brk_sw_on, release_pend} !== {m_ret, m_ring, m_brk, m_pend}) begin
      bad++;
      $display("FAIL %s ret/ring/brk/pend actual=%b%b%b%b expected=%b%b%b%b", phase,
               ret_sw_on, ring_sw_on, brk_sw_on, release_pend, m_ret, m_ring, m_brk, m_pend);
    end
  endtask

  always @(negedge clk) if (!rst) check_outs();

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zc_once();
    @(negedge clk) zc_pulse = 1'b1;
    @(negedge clk) zc_pulse = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run(3);
    // R1: outputs held off during reset
    total++;
    if ({ret_sw_on, ring_sw_on, brk_sw_on, release_pend} !== 4'b0000) begin
      bad++;
      $display("FAIL R1 actual=%b%b%b%b expected=0000", ret_sw_on, ring_sw_on, brk_sw_on, release_pend);
    end
    rst = 1'b0;
    phase = "R12"; shdn_n = 1'b1; run(8);           // latency into talk state
    phase = "R3";  run(4);
    phase = "R10"; zc_once(); run(6);                // stray zero crossing in talk
    phase = "R2";  ring_req = 1'b1; run(8);          // R8 transparent latch
    phase = "R10"; zc_once(); run(6);                // zc while ringing commanded
    phase = "R4";  ring_req = 1'b0; run(10);         // make-before-break
    phase = "R11"; zc_once(); run(6);
    phase = "R8";  ring_req = 1'b1; run(8);
    phase = "R9";  hold_en = 1'b1; run(6);
    ring_req = 1'b0; run(8); ring_req = 1'b1; run(3); ring_req = 1'b0; run(8);
    phase = "R8";  hold_en = 1'b0; run(8);
    ring_req = 1'b1; run(8);
    phase = "R6";  shdn_n = 1'b0; run(10);           // break-before-make
    phase = "R11"; zc_once(); run(6);
    phase = "R5";  ring_req = 1'b0; run(4); ring_req = 1'b1; run(8);
    zc_once(); run(4);
    phase = "R7";  shdn_n = 1'b1; run(8);
    ring_req = 1'b0; run(8);
    phase = "R5";  shdn_n = 1'b0; run(8);
    phase = "R7";  shdn_n = 1'b1; run(8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule